// File: doc/BRIEF.md
# Four-Tap Cascadable Transposed FIR Core

This block is a four-tap finite impulse response filter in transposed form. Each clock cycle one unsigned 6-bit sample is registered and offered to all four taps at once. Each tap multiplies that sample by its own unsigned 6-bit weight. It adds the 12-bit product, zero-extended, to the 16-bit partial sum handed on by the previous tap, and registers the result for the next tap. The last tap's register drives the sum output.

The weights are programmed through one shared 6-bit port. A write strobe and a 2-bit tap index travel with the value. All three are staged in one register, and the staged index is decoded one-hot to pick the tap whose weight register loads. A 16-bit accumulator input at the head of the chain and a registered copy of the sample let several cores be chained into a longer filter. Arithmetic wraps modulo 2^16. A synchronous active-high reset clears every register.

Top module: `fir4_cascade_core`

## Requirements
- R1: With `rst` high at a rising edge, every register clears on that edge: `acc_out` and `sample_out` read 0 and all four tap weights become 0.
- R2: `sample_out` equals the value `sample_in` held at the previous rising edge.
- R3: `coef_in`, `coef_sel` and `coef_wr` are staged at edge m. When the staged strobe is 1, the weight of tap `coef_sel` loads at edge m+1 and first weights a product at edge m+2. Tap 0 is at the head of the chain and tap 3 drives `acc_out`.
- R4: While the staged strobe is 0, no tap weight changes, whatever `coef_sel` and `coef_in` carry.
- R5: A write loads only the addressed tap. The other three weights keep their values on that edge.
- R6: Let x(e) be the sample captured at edge e and w_k(e) the weight of tap k after edge e. After edge t, `acc_out` = acc_in(t-3) + w0(t-4)x(t-4) + w1(t-3)x(t-3) + w2(t-2)x(t-2) + w3(t-1)x(t-1).
- R7: Products are unsigned and zero-extended to 16 bits. A sample of 63 with a weight of 63 adds 0x0F81.
- R8: The value on `acc_in` at edge e appears unchanged on `acc_out` after edge e+3 when every sample in that window is 0.
- R9: Sums wrap modulo 2^16 and no overflow is flagged. With all weights 63, the sample held at 63 and `acc_in` held at 0xFFFF, `acc_out` settles to 0x3E03.
- R10: With tap 3 weighted 0x3E, all other weights 0 and a single sample 0x12, `acc_out` reads 0x045C one edge after the sample is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all registers |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | 6 | Unsigned input sample |
| coef_in | input | 6 | Unsigned weight value to write |
| coef_sel | input | 2 | Index of the tap to write (0 = chain head) |
| coef_wr | input | 1 | Weight write strobe |
| acc_in | input | 16 | Partial sum from an upstream core, 0 when not chained |
| acc_out | output | 16 | Filtered sum after the last tap |
| sample_out | output | 6 | Registered sample for a downstream core |

## Verification
Two functions can fall on one edge. A weight rewrite can land on a tap in the same cycle that tap multiplies a streaming non-zero sample. A value arriving on `acc_in` can merge with products while samples keep flowing. The vector table provokes both: it writes weights in the middle of a stream of changing samples and non-zero accumulator inputs. Every cycle is judged against an equation model that pairs each tap's product with the weight that tap held on the edge before the product was summed. A weight applied one edge early or late therefore shows up as a wrong sum.

// File: rtl/fir4_pkg.sv
package fir4_pkg;
  localparam int SMP_W  = 6;
  localparam int WGT_W  = 6;
  localparam int ACC_W  = 16;
  localparam int N_TAPS = 4;
endpackage

// File: rtl/fir4_in_stage.sv
module fir4_in_stage #(
  parameter int SMP_W = 6,
  parameter int WGT_W = 6,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SMP_W-1:0] smp_d,
  input  logic [WGT_W-1:0] wgt_d,
  input  logic [SEL_W-1:0] sel_d,
  input  logic             wr_d,
  output logic [SMP_W-1:0] smp_q,
  output logic [WGT_W-1:0] wgt_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             wr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q <= '0;
      wgt_q <= '0;
      sel_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      smp_q <= smp_d;
      wgt_q <= wgt_d;
      sel_q <= sel_d;
      wr_q  <= wr_d;
    end
  end
endmodule

// File: rtl/fir4_wsel_decode.sv
module fir4_wsel_decode #(
  parameter int N_TAPS = 4,
  parameter int SEL_W  = 2
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic              wr,
  output logic [N_TAPS-1:0] load
);
  for (genvar k = 0; k < N_TAPS; k++) begin : g_dec
    assign load[k] = wr && (sel == SEL_W'(k));
  end
endmodule

// File: rtl/fir4_tap.sv
module fir4_tap #(
  parameter int SMP_W = 6,
  parameter int WGT_W = 6,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WGT_W-1:0] wgt_d,
  input  logic [SMP_W-1:0] smp,
  input  logic [ACC_W-1:0] acc_prev,
  output logic [ACC_W-1:0] acc_q,
  output logic [WGT_W-1:0] wgt_q
);
  localparam int PROD_W = SMP_W + WGT_W;
  localparam int PAD_W  = ACC_W - PROD_W;

  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  prod_ext;

  assign prod     = smp * wgt_q;
  assign prod_ext = {{PAD_W{1'b0}}, prod};

  always_ff @(posedge clk) begin
    if (rst)       wgt_q <= '0;
    else if (load) wgt_q <= wgt_d;
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_prev + prod_ext;
  end

  // R4: a weight without a load keeps its value
  a_r4_wgt_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(wgt_q));

  // R3: a load takes the staged value on the next edge
  a_r3_wgt_load: assert property (@(posedge clk) disable iff (rst)
    load |=> wgt_q == $past(wgt_d));
endmodule

// File: rtl/fir4_cascade_core.sv
module fir4_cascade_core
  import fir4_pkg::*;
#(
  parameter int SMP_BITS = SMP_W,
  parameter int WGT_BITS = WGT_W,
  parameter int ACC_BITS = ACC_W,
  parameter int TAPS     = N_TAPS
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [SMP_BITS-1:0]      sample_in,
  input  logic [WGT_BITS-1:0]      coef_in,
  input  logic [$clog2(TAPS)-1:0]  coef_sel,
  input  logic                     coef_wr,
  input  logic [ACC_BITS-1:0]      acc_in,
  output logic [ACC_BITS-1:0]      acc_out,
  output logic [SMP_BITS-1:0]      sample_out
);
  localparam int SEL_BITS = $clog2(TAPS);

  logic [SMP_BITS-1:0] smp_r;
  logic [WGT_BITS-1:0] wgt_r;
  logic [SEL_BITS-1:0] sel_r;
  logic                wr_r;
  logic [TAPS-1:0]     tap_load;
  logic [ACC_BITS-1:0] chain [TAPS+1];
  logic [WGT_BITS-1:0] tap_wgt [TAPS];

  fir4_in_stage #(.SMP_W(SMP_BITS), .WGT_W(WGT_BITS), .SEL_W(SEL_BITS)) u_in (
    .clk(clk), .rst(rst),
    .smp_d(sample_in), .wgt_d(coef_in), .sel_d(coef_sel), .wr_d(coef_wr),
    .smp_q(smp_r), .wgt_q(wgt_r), .sel_q(sel_r), .wr_q(wr_r)
  );

  fir4_wsel_decode #(.N_TAPS(TAPS), .SEL_W(SEL_BITS)) u_dec (
    .sel(sel_r), .wr(wr_r), .load(tap_load)
  );

  assign chain[0] = acc_in;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    fir4_tap #(.SMP_W(SMP_BITS), .WGT_W(WGT_BITS), .ACC_W(ACC_BITS)) u_tap (
      .clk(clk), .rst(rst), .load(tap_load[k]), .wgt_d(wgt_r),
      .smp(smp_r), .acc_prev(chain[k]), .acc_q(chain[k+1]), .wgt_q(tap_wgt[k])
    );
  end

  assign acc_out    = chain[TAPS];
  assign sample_out = smp_r;

  // checker state: weights seen one edge earlier
  logic [WGT_BITS-1:0] wgt_prev [TAPS];
  logic [TAPS-1:0]     wgt_chg;
  always_ff @(posedge clk) begin
    for (int k = 0; k < TAPS; k++) wgt_prev[k] <= tap_wgt[k];
  end
  always_comb begin
    for (int k = 0; k < TAPS; k++) wgt_chg[k] = (tap_wgt[k] != wgt_prev[k]);
  end

  // R5: at most one tap weight changes per edge outside reset
  a_r5_single_tap: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $countones(wgt_chg) <= 1);

  // R2: sample passes to the output after one edge
  a_r2_sample_out: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sample_out == $past(sample_in));

  // R1: outputs read zero on the first cycle after reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (acc_out == '0) && (sample_out == '0));

  // R4: no staged strobe means no weight moves on the next edge
  a_r4_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !wr_r |=> wgt_chg == '0);
endmodule

// File: tb/fir4_cascade_core_tb_top.sv
module fir4_cascade_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  sample_in = '0;
  logic [5:0]  coef_in = '0;
  logic [1:0]  coef_sel = '0;
  logic        coef_wr = 1'b0;
  logic [15:0] acc_in = '0;
  logic [15:0] acc_out;
  logic [5:0]  sample_out;

  always #2 clk = ~clk;

  fir4_cascade_core dut_i (
    .clk(clk), .rst(rst), .sample_in(sample_in), .coef_in(coef_in),
    .coef_sel(coef_sel), .coef_wr(coef_wr), .acc_in(acc_in),
    .acc_out(acc_out), .sample_out(sample_out)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  // equation model histories, indexed by edge
  int hu [0:2047];
  int hs [0:2047];
  int hci[0:2047];
  int ha [0:2047];
  int hw [0:2047];
  int hr [0:2047];
  int hc [4][0:2047];
  int e = 0;
  int last_rst = 0;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_y(input int t);
    logic [15:0] y;
    int cap;
    y = '0;
    cap = t - 3;
    if (cap > last_rst) y = y + 16'(hs[cap]);
    for (int k = 0; k < 4; k++) begin
      cap = t - 4 + k;
      if (cap > last_rst) y = y + 16'(hu[cap] * hc[k][cap]);
    end
    return y;
  endfunction

  task automatic step(input string tag, input int u, input int c, input int a,
                      input int w, input int s, input int r);
    @(negedge clk);
    sample_in = 6'(u); coef_in = 6'(c); coef_sel = 2'(a);
    coef_wr = 1'(w); acc_in = 16'(s); rst = 1'(r);
    @(posedge clk);
    e++;
    hu[e] = u; hs[e] = s; hci[e] = c; ha[e] = a; hw[e] = w; hr[e] = r;
    if (r != 0) last_rst = e;
    for (int k = 0; k < 4; k++) begin
      if (r != 0) hc[k][e] = 0;
      else if (hr[e-1] == 0 && hw[e-1] != 0 && ha[e-1] == k) hc[k][e] = hci[e-1];
      else hc[k][e] = hc[k][e-1];
    end
    #1;
    check({tag, " R6 acc_out"}, acc_out, model_y(e));
    check({tag, " R2 sample_out"}, {10'd0, sample_out}, (r != 0) ? 16'd0 : 16'(u));
  endtask

  task automatic idle(input string tag, input int u, input int n);
    for (int i = 0; i < n; i++) step(tag, u, 0, 0, 0, 0, 0);
  endtask

  // vector: {sample, weight, sel, wr, acc_in}
  localparam logic [30:0] VEC [16] = '{
    {6'd3,  6'd7,  2'd0, 1'b1, 16'h0000},
    {6'd9,  6'd11, 2'd1, 1'b1, 16'h0010},
    {6'd21, 6'd2,  2'd2, 1'b1, 16'h0000},
    {6'd40, 6'd33, 2'd3, 1'b1, 16'h0100},
    {6'd1,  6'd0,  2'd0, 1'b0, 16'h0000},
    {6'd63, 6'd50, 2'd1, 1'b0, 16'h0ABC},
    {6'd17, 6'd19, 2'd0, 1'b1, 16'h0000},
    {6'd17, 6'd44, 2'd3, 1'b1, 16'h7FFF},
    {6'd0,  6'd5,  2'd2, 1'b1, 16'h0001},
    {6'd55, 6'd61, 2'd2, 1'b1, 16'hF000},
    {6'd8,  6'd0,  2'd1, 1'b0, 16'h0000},
    {6'd33, 6'd29, 2'd1, 1'b1, 16'h0042},
    {6'd2,  6'd63, 2'd0, 1'b1, 16'h0000},
    {6'd60, 6'd1,  2'd3, 1'b1, 16'hFFFF},
    {6'd5,  6'd0,  2'd0, 1'b0, 16'h1234},
    {6'd0,  6'd0,  2'd0, 1'b0, 16'h0000}
  };

  initial begin
    for (int i = 0; i < 2048; i++) begin
      hu[i] = 0; hs[i] = 0; hci[i] = 0; ha[i] = 0; hw[i] = 0; hr[i] = 1;
      for (int k = 0; k < 4; k++) hc[k][i] = 0;
    end

    // R1: reset state
    for (int i = 0; i < 3; i++) step("R1 reset", 0, 0, 0, 0, 0, 1);
    check("R1 acc_out after reset", acc_out, 16'h0000);
    check("R1 sample_out after reset", {10'd0, sample_out}, 16'h0000);

    // R10: worked example on tap 3
    step("R3 write tap3", 0, 6'h3E, 3, 1, 0, 0);
    idle("R3", 0, 3);
    step("R10", 6'h12, 0, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0);
    check("R10 single product", acc_out, 16'h045C);
    idle("R10", 0, 4);

    // R7: largest unsigned product, zero-extended
    step("R7 write tap3", 0, 63, 3, 1, 0, 0);
    idle("R7", 0, 3);
    step("R7", 63, 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 0);
    check("R7 max product", acc_out, 16'h0F81);
    idle("R7", 0, 4);

    // R4: strobe low, selector and value moving
    step("R4 no strobe", 1, 6'h15, 0, 0, 0, 0);
    step("R4 no strobe", 1, 6'h2A, 1, 0, 0, 0);
    step("R4 no strobe", 1, 6'h07, 2, 0, 0, 0);
    idle("R4", 1, 4);
    check("R4 weights unchanged", acc_out, 16'h003F);

    // R5: one tap written, others keep their weights
    step("R5 write tap1", 1, 5, 1, 1, 0, 0);
    idle("R5", 1, 5);
    check("R5 only tap1 changed", acc_out, 16'h0044);

    // R6/R3: table of vectors, writes landing mid-stream
    for (int i = 0; i < 16; i++)
      step("R6 vec", VEC[i][30:25], VEC[i][24:19], VEC[i][18:17], VEC[i][16], VEC[i][15:0], 0);
    idle("R6 drain", 0, 5);

    // R8: cascade input passes with zero samples
    for (int k = 0; k < 4; k++) step("R8 setup", 0, 0, k, 1, 0, 0);
    idle("R8", 0, 5);
    step("R8", 0, 0, 0, 0, 16'h1234, 0);
    idle("R8", 0, 3);
    check("R8 cascade latency", acc_out, 16'h1234);

    // R9: wrap modulo 2^16
    for (int k = 0; k < 4; k++) step("R9 setup", 0, 63, k, 1, 0, 0);
    for (int i = 0; i < 7; i++) step("R9", 63, 0, 0, 0, 16'hFFFF, 0);
    check("R9 wrapped sum", acc_out, 16'h3E03);

    // R1: mid-run reset clears weights and sums
    step("R1 mid reset", 63, 0, 0, 0, 16'hFFFF, 1);
    check("R1 acc_out cleared", acc_out, 16'h0000);
    check("R1 sample_out cleared", {10'd0, sample_out}, 16'h0000);
    idle("R1 weights cleared", 63, 6);
    check("R1 weights zero", acc_out, 16'h0000);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule